// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block is a 32-bit power-management status register. It merges a set of event sources into one active-low system-management interrupt line. Two bits are sticky latches. Event pulses set them and software clears them by writing a one. One of them is fed by a built-in periodic tick generator whose rate is selectable. The other is fed by a level from a slow clock domain, which passes through a synchroniser and a rising-edge detector before it sets the latch. Two bits follow their source signals live. Three bits are read-only summaries. Each summary is the OR of a subordinate status vector masked by its own enable vector.

Software reaches the block through a simple register port. The status word sits at one offset and the mask/control word at another. Each latched or live bit can raise the interrupt only when its matching mask bit is set. The summary bits have no mask bit here, because their sources are already masked. For the same reason they drive the interrupt directly. The slow-domain latch refuses a clear for a programmable number of core cycles after it was last set. This keeps a clear from racing the slow-domain event that set it.

Top module: `pm_smi_status`

## Requirements
- R1: After reset the status word reads 0 (with all event inputs low), the control word reads 0 and `smi_n_o` is 1. Status bits 31:7 always read 0. Any offset other than the status and control offsets reads 0.
- R2: Status bits 0 (periodic), 1 (slow event), 2 (serial-IRQ) and 3 (TCO) contribute to the interrupt only when the control-word bit at the same position (3:0) is 1.
- R3: Summary bits are: bit 4 = OR(trap_sts_i & trap_en_i), bit 5 = OR(usb_a_sts_i & usb_a_en_i), bit 6 = OR(usb_b_sts_i & usb_b_en_i). Each is 0 when its enables are all 0. Each drives the interrupt whatever the control word holds.
- R4: Writes to the status word have no effect on bits 2 to 6. These bits always show their live inputs.
- R5: Writing the status word clears bit 0 and bit 1 where the written bit is 1. A bit written as 0 is left unchanged.
- R6: The periodic bit sets once every BASE_PERIOD << rate core cycles, where rate is control-word bits 9:8. Any control-word write restarts the period, so the first set lands on the (BASE_PERIOD << rate)-th clock edge after the write edge.
- R7: A rising edge on `slow_evt_i` sets bit 1 on the (SYNC_STAGES+1)-th clock edge after the change. A falling edge sets nothing.
- R8: A clear of bit 1 is ignored until SETTLE_CYC+1 clock edges after the edge that set it. A clear on that edge, or on any later edge, is honoured.
- R9: If a set event and a write-one-clear reach the same sticky bit on the same edge, the bit stays 1.
- R10: `smi_n_o` is registered. It goes low on the first clock edge after an enabled or summary bit becomes 1. It goes back to 1 on the first edge after all of them are 0.
- R11: The control word reads back mask bits 3:0 and rate bits 9:8. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| acc_sel | input | 1 | Register access select |
| acc_we | input | 1 | Write strobe (with acc_sel) |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data |
| slow_evt_i | input | 1 | Event level from the slow clock domain |
| usb_a_sts_i | input | USB_A_W | First USB subordinate status vector |
| usb_a_en_i | input | USB_A_W | First USB subordinate enable vector |
| usb_b_sts_i | input | USB_B_W | Second USB subordinate status vector |
| usb_b_en_i | input | USB_B_W | Second USB subordinate enable vector |
| trap_sts_i | input | TRAP_W | Device trap status vector |
| trap_en_i | input | TRAP_W | Device trap enable vector |
| sirq_evt_i | input | 1 | Serial-IRQ decoder request level |
| tco_evt_i | input | 1 | TCO logic request level |
| smi_n_o | output | 1 | Active-low system-management interrupt |

## Verification
The bench builds the block with BASE_PERIOD 4, a 2-bit rate field, SETTLE_CYC 6, and subordinate vectors of 3, 2 and 4 bits. The short period lets it measure every rate value (4 to 32 cycles) exactly. It also lets it line a write-one-clear up with a tick on the same edge. The six-cycle settle window makes it possible to probe both edges of the ignored-clear interval. The narrow vectors allow full truth-table sweeps of all three summaries, and every mask value is swept against the live inputs.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
   localparam int STS_W    = 32;
   localparam int B_PER    = 0;
   localparam int B_SLOW   = 1;
   localparam int B_SIRQ   = 2;
   localparam int B_TCO    = 3;
   localparam int B_DMON   = 4;
   localparam int B_USBA   = 5;
   localparam int B_USBB   = 6;
   localparam int N_MASKED = 4;
   localparam int N_USED   = 7;
   localparam int RATE_LSB = 8;

   typedef struct packed {
      logic usb_b;
      logic usb_a;
      logic dmon;
      logic tco;
      logic sirq;
      logic slow;
      logic per;
   } smi_src_t;
endpackage

// File: rtl/smi_sync_edge.sv
module smi_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES:0] sh_q;

   initial begin
      AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("sync needs two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o) else $error("edge pulse longer than one cycle"); // R7
endmodule

// File: rtl/smi_period_gen.sv
module smi_period_gen #(
   parameter int BASE_PERIOD = 4,
   parameter int RATE_W      = 2,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              tick_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   initial begin
      AST_BASE_MIN: assert (BASE_PERIOD >= 2) else $error("period too short");
      AST_CNT_FITS: assert ((64'(BASE_PERIOD) << ((1 << RATE_W) - 1)) < (64'd1 << CNT_W))
         else $error("counter too narrow");
   end

   assign lim    = CNT_W'(BASE_PERIOD) << rate_i;
   assign tick_o = (cnt_q >= lim - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart_i || tick_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o) else $error("back-to-back ticks"); // R6
endmodule

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit #(
   parameter int GUARD_CYC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (GUARD_CYC == 0) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= 1'b0;
            else        q_o <= set_i | (q_o & ~clr_i);
         end
      end else begin : g_guard
         localparam int GW = $clog2(GUARD_CYC + 1);
         logic [GW-1:0] guard_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_o     <= 1'b0;
               guard_q <= '0;
            end else if (set_i) begin
               q_o     <= 1'b1;
               guard_q <= GW'(GUARD_CYC);
            end else begin
               if (clr_i && guard_q == '0) q_o <= 1'b0;
               if (guard_q != '0)          guard_q <= guard_q - 1'b1;
            end
         end
         AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i && guard_q != '0) |=> (q_o == $past(q_o)))
            else $error("clear honoured inside settle window"); // R8
      end
   endgenerate

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o) else $error("set event lost"); // R9
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> (q_o == $past(q_o))) else $error("sticky bit moved"); // R5
endmodule

// File: rtl/smi_summary.sv
module smi_summary #(
   parameter int W = 8
) (
   input  logic [W-1:0] sts_i,
   input  logic [W-1:0] en_i,
   output logic         any_o
);
   initial begin
      AST_SUM_WIDTH: assert (W >= 1) else $error("empty summary vector");
   end
   assign any_o = |(sts_i & en_i);
endmodule

// File: rtl/pm_smi_status.sv
module pm_smi_status
   import pm_smi_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int STS_OFF     = 'h10,
   parameter int EN_OFF      = 'h14,
   parameter int BASE_PERIOD = 1600000,
   parameter int RATE_W      = 2,
   parameter int SETTLE_CYC  = 3126,
   parameter int SYNC_STAGES = 2,
   parameter int USB_A_W     = 8,
   parameter int USB_B_W     = 8,
   parameter int TRAP_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_sel,
   input  logic               acc_we,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [31:0]        acc_wdata,
   output logic [31:0]        acc_rdata,
   input  logic               slow_evt_i,
   input  logic [USB_A_W-1:0] usb_a_sts_i,
   input  logic [USB_A_W-1:0] usb_a_en_i,
   input  logic [USB_B_W-1:0] usb_b_sts_i,
   input  logic [USB_B_W-1:0] usb_b_en_i,
   input  logic [TRAP_W-1:0]  trap_sts_i,
   input  logic [TRAP_W-1:0]  trap_en_i,
   input  logic               sirq_evt_i,
   input  logic               tco_evt_i,
   output logic               smi_n_o
);
   localparam int CNT_W = $clog2(BASE_PERIOD) + (1 << RATE_W);

   initial begin
      AST_RATE_FITS: assert (RATE_LSB + RATE_W <= STS_W) else $error("rate field overflows");
      AST_OFF_DISTINCT: assert (STS_OFF != EN_OFF) else $error("offsets collide");
      AST_OFF_FITS: assert (STS_OFF < (1 << ADDR_W) && EN_OFF < (1 << ADDR_W))
         else $error("offset beyond address width");
   end

   logic                wr_sts, wr_en, hit_sts, hit_en;
   logic [N_MASKED-1:0] mask_q;
   logic [RATE_W-1:0]   rate_q;
   logic                tick, slow_rise;
   logic                sum_dmon, sum_usb_a, sum_usb_b;
   logic                per_q, slow_q;
   smi_src_t            src;
   logic [STS_W-1:0]    sts_word, en_word;
   logic                contrib_any;
   logic                wdata_unused;

   assign hit_sts = acc_sel && (acc_addr == ADDR_W'(STS_OFF));
   assign hit_en  = acc_sel && (acc_addr == ADDR_W'(EN_OFF));
   assign wr_sts  = hit_sts && acc_we;
   assign wr_en   = hit_en  && acc_we;
   assign wdata_unused = ^acc_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         rate_q <= '0;
      end else if (wr_en) begin
         mask_q <= acc_wdata[N_MASKED-1:0];
         rate_q <= acc_wdata[RATE_LSB +: RATE_W];
      end
   end

   smi_period_gen #(.BASE_PERIOD(BASE_PERIOD), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_per (
      .clk(clk), .rst_n(rst_n), .restart_i(wr_en), .rate_i(rate_q), .tick_o(tick));

   smi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(slow_evt_i), .rise_o(slow_rise));

   smi_sticky_bit #(.GUARD_CYC(0)) u_per_bit (
      .clk(clk), .rst_n(rst_n), .set_i(tick),
      .clr_i(wr_sts && acc_wdata[B_PER]), .q_o(per_q));

   smi_sticky_bit #(.GUARD_CYC(SETTLE_CYC)) u_slow_bit (
      .clk(clk), .rst_n(rst_n), .set_i(slow_rise),
      .clr_i(wr_sts && acc_wdata[B_SLOW]), .q_o(slow_q));

   smi_summary #(.W(TRAP_W))  u_sum_dmon (.sts_i(trap_sts_i),  .en_i(trap_en_i),  .any_o(sum_dmon));
   smi_summary #(.W(USB_A_W)) u_sum_usba (.sts_i(usb_a_sts_i), .en_i(usb_a_en_i), .any_o(sum_usb_a));
   smi_summary #(.W(USB_B_W)) u_sum_usbb (.sts_i(usb_b_sts_i), .en_i(usb_b_en_i), .any_o(sum_usb_b));

   always_comb begin
      src.per   = per_q;
      src.slow  = slow_q;
      src.sirq  = sirq_evt_i;
      src.tco   = tco_evt_i;
      src.dmon  = sum_dmon;
      src.usb_a = sum_usb_a;
      src.usb_b = sum_usb_b;
      sts_word  = STS_W'(src);
      en_word   = '0;
      en_word[N_MASKED-1:0]       = mask_q;
      en_word[RATE_LSB +: RATE_W] = rate_q;
   end

   assign contrib_any = |(sts_word[N_MASKED-1:0] & mask_q) | src.dmon | src.usb_a | src.usb_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_n_o <= 1'b1;
      else        smi_n_o <= ~contrib_any;
   end

   always_comb begin
      if (hit_sts)     acc_rdata = sts_word;
      else if (hit_en) acc_rdata = en_word;
      else             acc_rdata = '0;
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit_sts |-> (acc_rdata[STS_W-1:N_USED] == '0)) else $error("reserved bits set"); // R1
   AST_SMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && !sum_dmon && !sum_usb_a && !sum_usb_b) |=> smi_n_o)
      else $error("interrupt without enabled source"); // R2
   AST_SUM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_usb_a || sum_usb_b || sum_dmon) |=> !smi_n_o)
      else $error("summary bit did not raise interrupt"); // R3
   AST_SMI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(smi_n_o) |-> !$past(sum_dmon || sum_usb_a || sum_usb_b))
      else $error("interrupt released while summary active"); // R10
endmodule

// File: tb/tb_pm_smi_status.sv
`timescale 1ns/1ps
module tb_pm_smi_status;
   localparam int AW = 8, STS_A = 'h10, EN_A = 'h14, BP = 4, RW = 2, SETC = 6;
   localparam int UA = 3, UB = 2, TW = 4, SS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic acc_sel, acc_we;
   logic [AW-1:0] acc_addr;
   logic [31:0] acc_wdata, acc_rdata;
   logic slow_evt, sirq, tco, smi_n;
   logic [UA-1:0] ua_s, ua_e;
   logic [UB-1:0] ub_s, ub_e;
   logic [TW-1:0] tr_s, tr_e;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   pm_smi_status #(.ADDR_W(AW), .STS_OFF(STS_A), .EN_OFF(EN_A), .BASE_PERIOD(BP),
      .RATE_W(RW), .SETTLE_CYC(SETC), .SYNC_STAGES(SS), .USB_A_W(UA), .USB_B_W(UB),
      .TRAP_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .slow_evt_i(slow_evt),
      .usb_a_sts_i(ua_s), .usb_a_en_i(ua_e), .usb_b_sts_i(ub_s), .usb_b_en_i(ub_e),
      .trap_sts_i(tr_s), .trap_en_i(tr_e), .sirq_evt_i(sirq), .tco_evt_i(tco),
      .smi_n_o(smi_n));

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      acc_we = 1'b1; acc_addr = AW'(a); acc_wdata = d;
      @(negedge clk);
      acc_we = 1'b0; acc_addr = AW'(STS_A); acc_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      acc_addr = AW'(a);
      #1;
      d = acc_rdata;
      acc_addr = AW'(STS_A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic exp;
      int first;
      acc_sel = 1'b1; acc_we = 1'b0; acc_addr = AW'(STS_A); acc_wdata = '0;
      slow_evt = 0; sirq = 0; tco = 0;
      ua_s = '0; ua_e = '0; ub_s = '0; ub_e = '0; tr_s = '0; tr_e = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and decode
      rd(STS_A, d); chk("R1 status after reset", d, 32'h0);
      rd(EN_A, d);  chk("R1 control after reset", d, 32'h0);
      chk("R1 smi_n after reset", 32'(smi_n), 32'h1);

      // R11 control readback
      wr(EN_A, 32'hFFFF_FFFF);
      rd(EN_A, d);  chk("R11 control readback", d, 32'h0000_030F);
      rd('h18, d);  chk("R1 unmapped offset", d, 32'h0);
      wr(EN_A, 32'h0);

      // R3 exhaustive summaries
      for (int v = 0; v < 64; v++) begin
         ua_s = v[2:0]; ua_e = v[5:3]; exp = |(ua_s & ua_e);
         rd(STS_A, d); chk("R3 usb_a summary", 32'(d[5]), 32'(exp));
         @(negedge clk); chk("R3 usb_a drives smi", 32'(smi_n), 32'(!exp));
      end
      ua_s = '0; ua_e = '0;
      for (int v = 0; v < 16; v++) begin
         ub_s = v[1:0]; ub_e = v[3:2]; exp = |(ub_s & ub_e);
         rd(STS_A, d); chk("R3 usb_b summary", 32'(d[6]), 32'(exp));
         @(negedge clk); chk("R3 usb_b drives smi", 32'(smi_n), 32'(!exp));
      end
      ub_s = '0; ub_e = '0;
      for (int v = 0; v < 256; v++) begin
         tr_s = v[3:0]; tr_e = v[7:4]; exp = |(tr_s & tr_e);
         rd(STS_A, d); chk("R3 trap summary", 32'(d[4]), 32'(exp));
         @(negedge clk); chk("R3 trap drives smi", 32'(smi_n), 32'(!exp));
      end
      tr_s = '0; tr_e = '0;

      // R2 mask sweep against live and latched bits
      for (int m = 0; m < 16; m++) begin
         for (int i = 0; i < 4; i++) begin
            wr(EN_A, 32'(m));
            sirq = i[0]; tco = i[1];
            rd(STS_A, d);
            exp = |((d[3:0] & 4'(m)) | d[6:4]);
            @(negedge clk);
            chk("R2 masked interrupt", 32'(smi_n), 32'(!exp));
         end
      end
      sirq = 0; tco = 0;

      // R4 read-only bits ignore writes
      sirq = 1; ua_s = 3'b001; ua_e = 3'b001;
      wr(EN_A, 32'h0);
      wr(STS_A, 32'hFFFF_FFFF);
      rd(STS_A, d); chk("R4 ro bits after ones write", 32'(d[6:2]), 32'h09);
      chk("R1 reserved bits", 32'(d[31:7]), 32'h0);
      wr(STS_A, 32'h0);
      rd(STS_A, d); chk("R4 ro bits after zeros write", 32'(d[6:2]), 32'h09);
      sirq = 0; ua_s = '0; ua_e = '0;

      // R10 registered interrupt timing
      wr(EN_A, 32'h8);
      @(negedge clk);
      tco = 1; #1;
      chk("R10 no change before edge", 32'(smi_n), 32'h1);
      @(negedge clk); chk("R10 assert one edge later", 32'(smi_n), 32'h0);
      tco = 0;
      @(negedge clk); chk("R10 release one edge later", 32'(smi_n), 32'h1);

      // R6 period per rate
      for (int r = 0; r < 4; r++) begin
         wr(EN_A, 32'(r) << 8);
         wr(STS_A, 32'h1);
         rd(STS_A, d); chk("R6 periodic cleared", 32'(d[0]), 32'h0);
         first = 0;
         for (int k = 2; k <= BP * 8 + 4; k++) begin
            @(negedge clk);
            rd(STS_A, d);
            if (d[0] && first == 0) first = k;
         end
         chk("R6 period edges", 32'(first), 32'(BP << r));
      end

      // R5 write-one-clear semantics
      wr(EN_A, 32'h300);
      first = 0;
      for (int k = 1; k <= 40 && first == 0; k++) begin
         rd(STS_A, d);
         if (d[0]) first = k; else @(negedge clk);
      end
      wr(STS_A, 32'h0);
      rd(STS_A, d); chk("R5 zero write keeps bit", 32'(d[0]), 32'h1);
      wr(STS_A, 32'h1);
      rd(STS_A, d); chk("R5 one write clears bit", 32'(d[0]), 32'h0);

      // R9 tick and clear on the same edge
      wr(EN_A, 32'h0);
      repeat (7) @(negedge clk);
      wr(STS_A, 32'h1);
      rd(STS_A, d); chk("R9 set wins over clear", 32'(d[0]), 32'h1);
      wr(STS_A, 32'h1);
      rd(STS_A, d); chk("R9 later clear works", 32'(d[0]), 32'h0);

      // R7 slow event latency, R8 settle window
      slow_evt = 1;
      @(negedge clk); rd(STS_A, d); chk("R7 not yet after one edge", 32'(d[1]), 32'h0);
      @(negedge clk); rd(STS_A, d); chk("R7 not yet after two edges", 32'(d[1]), 32'h0);
      @(negedge clk); rd(STS_A, d); chk("R7 set after three edges", 32'(d[1]), 32'h1);
      wr(STS_A, 32'h2);
      rd(STS_A, d); chk("R8 early clear ignored", 32'(d[1]), 32'h1);
      repeat (SETC - 2) @(negedge clk);
      wr(STS_A, 32'h2);
      rd(STS_A, d); chk("R8 last blocked edge", 32'(d[1]), 32'h1);
      wr(STS_A, 32'h2);
      rd(STS_A, d); chk("R8 clear after window", 32'(d[1]), 32'h0);
      slow_evt = 0;
      repeat (4) @(negedge clk);
      rd(STS_A, d); chk("R7 falling edge sets nothing", 32'(d[1]), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule